// File: doc/BRIEF.md
# Processor-Integrated Parallel Port with Memory-Map Controls

This block is the six-line bidirectional port that lives inside the processor. It responds to two zero-page locations: address 0 holds the direction register, where a bit at 1 makes the matching line an output and a bit at 0 makes it an input. Address 1 holds the data register. When the processor reads or writes either location, the block flags the access as its own so that the external RAM stays out of the cycle.

Lines set as outputs drive the data-register value. Lines set as inputs are sampled on every clock. The three lowest lines also feed the memory-banking decoder: one selects the lower ROM window, one the upper ROM window, and one picks between the character ROM and I/O. A line that is configured as an input presents a 1 to the decoder, as a pull-up would. Line 3 carries the cassette write signal and line 5 the motor control, where 0 means the motor runs. Line 4 senses the play switch, where 0 means the button is down. The usual working direction value is 47, which makes every line an output except line 4.

The port keeps working for the cassette even when the cartridge configuration makes the decoder ignore the banking lines. That choice belongs to the decoder, not to this block.

Top module: `cpu_io_port`

## Requirements
- R1: While reset is asserted and after it is released, both registers are zero. So pin_oe_o is 0, pin_out_o is 0, map_sel_o is 3'b111, and a read of address 0 returns 0.
- R2: port_hit_o is 1 exactly when bus_valid_i is 1 and addr_i is 0 or 1. It is 0 for every other address and whenever bus_valid_i is 0.
- R3: A write to address 0 loads wdata_i[5:0] into the direction register on the clock edge. A following read of address 0 returns that value with bits 7:6 at 0.
- R4: A write to address 1 loads wdata_i[5:0] into the data register on the clock edge.
- R5: pin_oe_o equals the direction register and pin_out_o equals the data register, bit for bit.
- R6: A read of address 1 returns, in bit k for k from 0 to 5, the data-register bit if direction bit k is 1. Otherwise it returns the level pin_in_i[k] had at the most recent clock edge. Bits 7:6 read 0.
- R7: map_sel_o[k], for k from 0 to 2, is the data-register bit k when direction bit k is 1 and is 1 when it is 0. The value changes only after the edge that completes a write, never during the write cycle itself.
- R8: Writes to any address other than 0 or 1, and any bus cycle with bus_valid_i at 0, leave both registers unchanged.
- R9: rdata_o is 0 in every cycle that is not a valid read of address 0 or 1, including valid write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Processor bus cycle in progress |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Processor address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the same cycle as the read |
| port_hit_o | output | 1 | Access belongs to the port; external RAM must be kept off the bus |
| pin_in_i | input | 6 | Line levels sampled from the pins |
| pin_out_o | output | 6 | Value driven on the lines |
| pin_oe_o | output | 6 | Per-line output enable |
| map_sel_o | output | 3 | Banking controls to the memory decoder: [0] lower ROM, [1] upper ROM, [2] character ROM or I/O |

## Verification
The bench sweeps all 4096 pairs of direction and data values. For each pair it drives a pin pattern different from the data, which exposes a read mux with its select inverted or a pin path that bypasses the sample register. A decoder that matched only the low address bits would claim mirror locations such as 0x0100 and 0xFFFF. A port that updated its registers without checking valid or address would take in the stray writes that the bench sends there. The bench checks the banking outputs during the write cycle as well as after it, which catches a bypass that lets new values leak out early. It also checks that input-configured lines read as 1 at the decoder and not as the data bit.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DAT  = 2'd2
  } port_sel_e;
endpackage

// File: rtl/ioport_decode.sv
module ioport_decode
  import ioport_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DIR_ADDR = 0,
  parameter int unsigned DAT_ADDR = 1
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output port_sel_e         sel_o,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] DirA = ADDR_W'(DIR_ADDR);
  localparam logic [ADDR_W-1:0] DatA = ADDR_W'(DAT_ADDR);

  always_comb begin
    sel_o = SEL_NONE;
    if (valid_i) begin
      if (addr_i == DirA)      sel_o = SEL_DIR;
      else if (addr_i == DatA) sel_o = SEL_DAT;
    end
  end

  assign hit_o = (sel_o != SEL_NONE);
endmodule

// File: rtl/ioport_regs.sv
module ioport_regs
  import ioport_pkg::*;
#(
  parameter int unsigned PORT_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  port_sel_e         sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PORT_W-1:0] dir_o,
  output logic [PORT_W-1:0] dat_o
);
  logic unused_hi;
  assign unused_hi = ^wdata_i[DATA_W-1:PORT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      dat_o <= '0;
    end else if (wr_i) begin
      if (sel_i == SEL_DIR) dir_o <= wdata_i[PORT_W-1:0];
      if (sel_i == SEL_DAT) dat_o <= wdata_i[PORT_W-1:0];
    end
  end
endmodule

// File: rtl/ioport_pinmux.sv
module ioport_pinmux
  import ioport_pkg::*;
#(
  parameter int unsigned PORT_W = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MAP_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  port_sel_e         sel_i,
  input  logic [PORT_W-1:0] dir_i,
  input  logic [PORT_W-1:0] dat_i,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pin_oe_o,
  output logic [PORT_W-1:0] pin_out_o,
  output logic [MAP_W-1:0]  map_sel_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [PORT_W-1:0] pin_q;
  logic [PORT_W-1:0] line_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_i;
  end

  for (genvar k = 0; k < PORT_W; k++) begin : g_line
    assign line_rd[k] = dir_i[k] ? dat_i[k] : pin_q[k];
  end

  // input-configured banking lines float high toward the decoder
  for (genvar m = 0; m < MAP_W; m++) begin : g_map
    assign map_sel_o[m] = dir_i[m] ? dat_i[m] : 1'b1;
  end

  assign pin_oe_o  = dir_i;
  assign pin_out_o = dat_i;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (sel_i)
        SEL_DIR: rdata_o = DATA_W'(dir_i);
        SEL_DAT: rdata_o = DATA_W'(line_rd);
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cpu_io_port.sv
module cpu_io_port
  import ioport_pkg::*;
#(
  parameter int unsigned PORT_W   = 6,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MAP_W    = 3,
  parameter int unsigned DIR_ADDR = 0,
  parameter int unsigned DAT_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              port_hit_o,
  input  logic [PORT_W-1:0] pin_in_i,
  output logic [PORT_W-1:0] pin_out_o,
  output logic [PORT_W-1:0] pin_oe_o,
  output logic [MAP_W-1:0]  map_sel_o
);
  port_sel_e         sel;
  logic              hit;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] dat_q;

  ioport_decode #(
    .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR)
  ) u_decode (
    .valid_i(bus_valid_i), .addr_i(addr_i), .sel_o(sel), .hit_o(hit)
  );

  ioport_regs #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(hit & bus_we_i), .sel_i(sel),
    .wdata_i(wdata_i), .dir_o(dir_q), .dat_o(dat_q)
  );

  ioport_pinmux #(.PORT_W(PORT_W), .DATA_W(DATA_W), .MAP_W(MAP_W)) u_pinmux (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(hit & ~bus_we_i), .sel_i(sel),
    .dir_i(dir_q), .dat_i(dat_q), .pin_i(pin_in_i),
    .pin_oe_o(pin_oe_o), .pin_out_o(pin_out_o), .map_sel_o(map_sel_o),
    .rdata_o(rdata_o)
  );

  assign port_hit_o = hit;
endmodule

// File: rtl/ioport_chk.sv
module ioport_chk #(
  parameter int unsigned PORT_W = 6,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MAP_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              port_hit_o,
  input logic [PORT_W-1:0] pin_out_o,
  input logic [PORT_W-1:0] pin_oe_o,
  input logic [MAP_W-1:0]  map_sel_o
);
  logic wr_dir, wr_dat, any_wr, rd_hit;
  assign wr_dir = bus_valid_i && bus_we_i && (addr_i == ADDR_W'(0));
  assign wr_dat = bus_valid_i && bus_we_i && (addr_i == ADDR_W'(1));
  assign any_wr = wr_dir || wr_dat;
  assign rd_hit = bus_valid_i && !bus_we_i && (addr_i < ADDR_W'(2));

  a_r2_hit_only_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_hit_o |-> (bus_valid_i && addr_i < ADDR_W'(2)));
  a_r3_dir_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir |=> pin_oe_o == $past(wdata_i[PORT_W-1:0]));
  a_r4_dat_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dat |=> pin_out_o == $past(wdata_i[PORT_W-1:0]));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_wr |=> ($stable(pin_oe_o) && $stable(pin_out_o)));
  a_r7_map_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_sel_o == ((pin_out_o[MAP_W-1:0] & pin_oe_o[MAP_W-1:0]) | ~pin_oe_o[MAP_W-1:0]));
  a_r9_rdata_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |-> rdata_o == '0);
endmodule

bind cpu_io_port ioport_chk #(
  .PORT_W(PORT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAP_W(MAP_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_valid_i(bus_valid_i), .bus_we_i(bus_we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .port_hit_o(port_hit_o),
  .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o), .map_sel_o(map_sel_o)
);

// File: tb/cpu_io_port_tb.sv
module cpu_io_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic       we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       hit;
  logic [5:0] pin_in = '0;
  logic [5:0] pin_out, pin_oe;
  logic [2:0] map_sel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_io_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .port_hit_o(hit),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe), .map_sel_o(map_sel)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_map(input logic [5:0] d, input logic [5:0] v);
    return (v[2:0] & d[2:0]) | ~d[2:0];
  endfunction

  // drive at negedge, the write lands on the following posedge
  task automatic bus_write(input logic [15:0] a, input logic [7:0] v, input logic vld);
    @(negedge clk);
    valid = vld; we = 1'b1; addr = a; wdata = v;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
  endtask

  // combinational read in the low phase
  task automatic bus_read(input logic [15:0] a, output logic [7:0] v, output logic h);
    valid = 1'b1; we = 1'b0; addr = a;
    #1;
    v = rdata; h = hit;
    valid = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    logic [7:0] rv;
    logic       rh;
    logic [5:0] d_prev, v_prev;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk("R1 oe in reset", 16'(pin_oe), 16'h0);
    chk("R1 map in reset", 16'(map_sel), 16'h7);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe", 16'(pin_oe), 16'h0);
    chk("R1 out", 16'(pin_out), 16'h0);
    chk("R1 map", 16'(map_sel), 16'h7);
    bus_read(16'h0000, rv, rh);
    chk("R1 read dir", 16'(rv), 16'h0);

    // R2 decode sweep
    for (int a = 0; a < 1024; a++) begin
      bus_read(16'(a), rv, rh);
      chk("R2 hit", 16'(rh), 16'(a < 2));
    end
    foreach (addr[i]) begin
      bus_read(16'h1 << i, rv, rh);
      chk("R2 hit single bit", 16'(rh), 16'(i == 0));
    end
    bus_read(16'hFFFF, rv, rh);
    chk("R2 hit top", 16'(rh), 16'h0);
    valid = 1'b0; addr = 16'h0001; we = 1'b0; #1;
    chk("R2 hit no valid", 16'(hit), 16'h0);
    chk("R9 rdata no valid", 16'(rdata), 16'h0);

    // R9 in a write cycle and for a non-port read
    @(negedge clk);
    valid = 1'b1; we = 1'b1; addr = 16'h0001; wdata = 8'hFF; #1;
    chk("R9 rdata write", 16'(rdata), 16'h0);
    chk("R7 map before edge", 16'(map_sel), 16'h7);
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
    bus_read(16'h0100, rv, rh);
    chk("R9 rdata mirror", 16'(rv), 16'h0);

    // Main sweep over direction and data values
    for (int d = 0; d < 64; d++) begin
      for (int v = 0; v < 64; v++) begin
        logic [5:0] p;
        p = 6'((v * 5 + d * 3) & 63) ^ 6'h2A;
        bus_write(16'h0000, 8'(d) | 8'hC0, 1'b1);
        @(negedge clk);
        pin_in = p;
        valid = 1'b1; we = 1'b1; addr = 16'h0001; wdata = 8'(v) | 8'h80;
        #1;
        chk("R7 map held during write", 16'(map_sel), 16'(exp_map(6'(d), pin_out)));
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0; we = 1'b0;
        pin_in = ~p;
        chk("R5 oe", 16'(pin_oe), 16'(d));
        chk("R4 out", 16'(pin_out), 16'(v));
        chk("R7 map", 16'(map_sel), 16'(exp_map(6'(d), 6'(v))));
        bus_read(16'h0001, rv, rh);
        chk("R6 read data", 16'(rv), 16'((v & d) | (p & ~d & 6'h3F)));
        bus_read(16'h0000, rv, rh);
        chk("R3 read dir", 16'(rv), 16'(d));
      end
    end

    // R8 stray writes
    bus_write(16'h0000, 8'h2F, 1'b1);
    bus_write(16'h0001, 8'h15, 1'b1);
    d_prev = 6'h2F; v_prev = 6'h15;
    bus_write(16'h0002, 8'h00, 1'b1);
    bus_write(16'h0100, 8'h00, 1'b1);
    bus_write(16'h0101, 8'h00, 1'b1);
    bus_write(16'hFFFF, 8'h00, 1'b1);
    bus_write(16'h0000, 8'h00, 1'b0);
    bus_write(16'h0001, 8'h3F, 1'b0);
    chk("R8 dir kept", 16'(pin_oe), 16'(d_prev));
    chk("R8 data kept", 16'(pin_out), 16'(v_prev));
    chk("R8 map kept", 16'(map_sel), 16'(exp_map(d_prev, v_prev)));
    bus_read(16'h0000, rv, rh);
    chk("R8 dir readback", 16'(rv), 16'(d_prev));

    // R1 again after a second reset
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk("R1 async clear oe", 16'(pin_oe), 16'h0);
    chk("R1 async clear map", 16'(map_sel), 16'h7);
    @(negedge clk);
    rst_n = 1'b1;

    finish_run();
  end
endmodule